// File: doc/BRIEF.md
# Interrupt Destination Matcher and Round-Robin Arbiter

This block decides which of N target agents receive an interprocessor interrupt request. Each request carries an 8-bit destination, a physical/logical addressing bit, a 2-bit shorthand, the index of the sending agent and a flag that selects lowest-priority delivery. Each target supplies its physical ID, its logical ID, a 2-bit logical-format selector and an enabled flag. All of these are sampled when `req_valid` is high.

For ordinary (fixed) delivery, the result is the mask of every target that matches the addressing. For lowest-priority delivery, the block picks exactly one target that both matches and is enabled. It searches in rotation from the index after the previous winner, which spreads such interrupts fairly across the agents. The result is registered. It appears as a one-cycle `dlv_valid` pulse with `dlv_mask` in the cycle after the request.

Top module: `ipi_route_arbiter`

## Requirements
- R1: Shorthand 2'b00 addresses by the destination field. 2'b01 matches only target `req_sender`. 2'b10 matches every target. 2'b11 matches every target except `req_sender`. For shorthands other than 2'b00, the destination and addressing mode are ignored.
- R2: With shorthand 2'b00 and `req_logical`=0, a target matches when `req_dest` equals its physical ID, or when `req_dest` is 8'hFF (broadcast).
- R3: With `req_logical`=1 and a target format of 2'b01 (flat), the target matches when the bitwise AND of its logical ID and `req_dest` is nonzero.
- R4: With `req_logical`=1 and a target format of 2'b10 (cluster), the target matches when bits [7:4] of its logical ID equal `req_dest[7:4]` and the AND of the two lower nibbles is nonzero.
- R5: A target whose format selector is 2'b00 or 2'b11 never matches in logical mode.
- R6: When `req_lowest`=0, `dlv_mask` equals the set of matched targets, whatever their enabled flags.
- R7: When `req_lowest`=1, `dlv_mask` has exactly the one bit of the first target that is matched and enabled. The search starts at (pointer+1) and wraps modulo N.
- R8: After a lowest-priority request that finds a winner, the pointer becomes the winner's index. If no target qualifies, `dlv_mask` is zero and the pointer is unchanged.
- R9: `dlv_valid` and `dlv_mask` are driven in the cycle after a request is sampled. In any cycle after no request, `dlv_valid` is 0 and `dlv_mask` is zero.
- R10: Synchronous active-low reset clears `dlv_valid` and `dlv_mask`. It also sets the pointer to N-1, so the first lowest-priority search begins at target 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_dest | input | IDW | Destination field |
| req_logical | input | 1 | 0 = physical addressing, 1 = logical addressing |
| req_shorthand | input | 2 | Destination shorthand |
| req_lowest | input | 1 | 1 = lowest-priority delivery to one target |
| req_sender | input | clog2(N) | Index of the sending agent |
| tgt_phys_id | input | N*IDW | Physical IDs, target i at bits [i*IDW +: IDW] |
| tgt_log_id | input | N*IDW | Logical IDs, same packing |
| tgt_fmt | input | 2*N | Logical format per target, bits [2i +: 2] |
| tgt_enable | input | N | Target accepts lowest-priority interrupts |
| dlv_valid | output | 1 | Result present |
| dlv_mask | output | N | Targets that receive the interrupt |

## Verification
The assertions assume that `req_sender` is always below N and that all request fields are stable and known whenever `req_valid` is high. They do not rely on the target tables being constant between requests. The bench keeps the target ID, format and enable vectors fixed across each group of requests and changes them only between requests. It drives every request field at the falling edge, so the sampled values are never in flux. Sender indices in the stimulus stay inside 0 to N-1.

// File: rtl/ipi_route_pkg.sv
// Shared encodings for the interrupt destination matcher.
// Assumes: shorthand and logical-format fields are 2 bits wide.
package ipi_route_pkg;
    typedef enum logic [1:0] {
        SH_DEST   = 2'b00,
        SH_SELF   = 2'b01,
        SH_ALL    = 2'b10,
        SH_OTHERS = 2'b11
    } shorthand_e;

    typedef enum logic [1:0] {
        FMT_NONE    = 2'b00,
        FMT_FLAT    = 2'b01,
        FMT_CLUSTER = 2'b10,
        FMT_RSVD    = 2'b11
    } lfmt_e;
endpackage

// File: rtl/ipi_dest_match.sv
// Decides whether one target is addressed by a request.
// Assumes: IDW is even. The cluster group is the upper half of the ID
// and the member mask is the lower half.
module ipi_dest_match
    import ipi_route_pkg::*;
#(
    parameter int IDW = 8,
    parameter int N   = 8,
    parameter int IDX = 0,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [IDW-1:0] dest,
    input  logic           logical,
    input  logic [1:0]     shorthand,
    input  logic [SW-1:0]  sender,
    input  logic [IDW-1:0] phys_id,
    input  logic [IDW-1:0] log_id,
    input  logic [1:0]     fmt,
    output logic           hit
);
    localparam int HALF = IDW / 2;
    localparam logic [SW-1:0] MY_IDX = SW'(IDX);

    logic phys_hit;
    logic flat_hit;
    logic clus_hit;
    logic logi_hit;

    // Physical and logical address comparisons.
    always_comb begin
        phys_hit = (dest == {IDW{1'b1}}) || (dest == phys_id);
        flat_hit = |(dest & log_id);
        clus_hit = (dest[IDW-1:HALF] == log_id[IDW-1:HALF]) &&
                   (|(dest[HALF-1:0] & log_id[HALF-1:0]));
        unique case (lfmt_e'(fmt))
            FMT_FLAT:    logi_hit = flat_hit;
            FMT_CLUSTER: logi_hit = clus_hit;
            default:     logi_hit = 1'b0;
        endcase
    end

    // Apply the shorthand on top of the addressed result.
    always_comb begin
        unique case (shorthand_e'(shorthand))
            SH_DEST:   hit = logical ? logi_hit : phys_hit;
            SH_SELF:   hit = (sender == MY_IDX);
            SH_ALL:    hit = 1'b1;
            default:   hit = (sender != MY_IDX);
        endcase
    end
endmodule

// File: rtl/ipi_rr_pick.sv
// Rotating first-one search: picks the first qualified index after ptr.
// Assumes: ptr < N. If nothing qualifies, found is 0 and grant is zero.
module ipi_rr_pick #(
    parameter int N = 8,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  qual,
    input  logic [PW-1:0] ptr,
    output logic [N-1:0]  grant,
    output logic          found,
    output logic [PW-1:0] win_idx
);
    // Walk N positions starting after ptr and take the first hit.
    always_comb begin
        int idx;
        grant   = '0;
        found   = 1'b0;
        win_idx = '0;
        idx     = 0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr) + 1 + k) % N;
            if (!found && qual[idx]) begin
                found      = 1'b1;
                grant[idx] = 1'b1;
                win_idx    = PW'(idx);
            end
        end
    end
endmodule

// File: rtl/ipi_route_arbiter.sv
// Top: matches a request against N targets and registers the delivery mask.
// Fixed delivery gives all matches. Lowest-priority delivery gives one
// enabled match, chosen by round robin.
// Assumes: req_sender < N. The result appears one cycle after req_valid.
module ipi_route_arbiter
    import ipi_route_pkg::*;
#(
    parameter int N   = 8,
    parameter int IDW = 8,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [IDW-1:0]   req_dest,
    input  logic             req_logical,
    input  logic [1:0]       req_shorthand,
    input  logic             req_lowest,
    input  logic [PW-1:0]    req_sender,
    input  logic [N*IDW-1:0] tgt_phys_id,
    input  logic [N*IDW-1:0] tgt_log_id,
    input  logic [2*N-1:0]   tgt_fmt,
    input  logic [N-1:0]     tgt_enable,
    output logic             dlv_valid,
    output logic [N-1:0]     dlv_mask
);
    logic [N-1:0]  hit;
    logic [N-1:0]  qual;
    logic [N-1:0]  grant;
    logic          found;
    logic [PW-1:0] win_idx;
    logic [PW-1:0] rr_ptr;

    for (genvar i = 0; i < N; i++) begin : g_match
        ipi_dest_match #(.IDW(IDW), .N(N), .IDX(i)) u_match (
            .dest      (req_dest),
            .logical   (req_logical),
            .shorthand (req_shorthand),
            .sender    (req_sender),
            .phys_id   (tgt_phys_id[i*IDW +: IDW]),
            .log_id    (tgt_log_id[i*IDW +: IDW]),
            .fmt       (tgt_fmt[2*i +: 2]),
            .hit       (hit[i])
        );
    end

    // Only enabled matches compete for lowest-priority delivery.
    always_comb qual = hit & tgt_enable;

    ipi_rr_pick #(.N(N)) u_pick (
        .qual    (qual),
        .ptr     (rr_ptr),
        .grant   (grant),
        .found   (found),
        .win_idx (win_idx)
    );

    // Register the result and advance the rotation pointer on a win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_valid <= 1'b0;
            dlv_mask  <= '0;
            rr_ptr    <= PW'(N - 1);
        end else begin
            dlv_valid <= req_valid;
            if (!req_valid)
                dlv_mask <= '0;
            else if (req_lowest)
                dlv_mask <= grant;
            else
                dlv_mask <= hit;
            if (req_valid && req_lowest && found)
                rr_ptr <= win_idx;
        end
    end
endmodule

// File: rtl/ipi_route_arbiter_chk.sv
// Temporal checks on the arbiter's ports, attached with bind.
// Assumes: req_sender < N whenever req_valid is high.
module ipi_route_arbiter_chk #(
    parameter int N   = 8,
    parameter int IDW = 8,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_shorthand,
    input logic          req_lowest,
    input logic [PW-1:0] req_sender,
    input logic [N-1:0]  tgt_enable,
    input logic          dlv_valid,
    input logic [N-1:0]  dlv_mask
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dlv_valid);

    assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!dlv_valid && dlv_mask == '0));

    assert_single_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_lowest) |=> $onehot0(dlv_mask));

    assert_winner_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_lowest) |=> ((dlv_mask & ~$past(tgt_enable)) == '0));

    assert_self_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_lowest && req_shorthand == 2'b01)
            |=> (dlv_mask == (ONE << $past(req_sender))));

    assert_all_incl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_lowest && req_shorthand == 2'b10) |=> (&dlv_mask));

    assert_excl_sender_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_shorthand == 2'b11) |=> !dlv_mask[$past(req_sender)]);
endmodule

bind ipi_route_arbiter ipi_route_arbiter_chk #(.N(N), .IDW(IDW)) u_chk (.*);

// File: tb/ipi_route_arbiter_bench.sv
module ipi_route_arbiter_bench;
    localparam int N   = 8;
    localparam int IDW = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [IDW-1:0]   req_dest = '0;
    logic             req_logical = 1'b0;
    logic [1:0]       req_shorthand = 2'b00;
    logic             req_lowest = 1'b0;
    logic [2:0]       req_sender = '0;
    logic [N*IDW-1:0] tgt_phys_id;
    logic [N*IDW-1:0] tgt_log_id;
    logic [2*N-1:0]   tgt_fmt;
    logic [N-1:0]     tgt_enable = '0;
    logic             dlv_valid;
    logic [N-1:0]     dlv_mask;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    ipi_route_arbiter #(.N(N), .IDW(IDW)) u_ipi_route_arbiter (.*);

    typedef struct packed {
        logic [7:0] dest;
        logic       lg;
        logic [1:0] sh;
        logic [2:0] snd;
        logic [7:0] exp;
    } vec_t;

    // Fixed-delivery vectors, with all targets disabled (R6).
    localparam vec_t VEC [0:11] = '{
        '{8'h13, 1'b0, 2'b00, 3'd0, 8'h08},  // R2 exact physical
        '{8'hFF, 1'b0, 2'b00, 3'd0, 8'hFF},  // R2 broadcast
        '{8'h55, 1'b0, 2'b00, 3'd0, 8'h00},  // R2 no match
        '{8'h05, 1'b1, 2'b00, 3'd0, 8'h05},  // R3 flat
        '{8'h23, 1'b1, 2'b00, 3'd0, 8'h33},  // R3 R4 mixed
        '{8'h31, 1'b1, 2'b00, 3'd0, 8'h41},  // R4 other cluster
        '{8'h24, 1'b1, 2'b00, 3'd0, 8'h04},  // R4 member mask miss
        '{8'hFF, 1'b1, 2'b00, 3'd0, 8'h0F},  // R5 invalid format ignored
        '{8'h00, 1'b0, 2'b01, 3'd5, 8'h20},  // R1 self
        '{8'h00, 1'b0, 2'b10, 3'd3, 8'hFF},  // R1 all incl
        '{8'h00, 1'b0, 2'b11, 3'd3, 8'hF7},  // R1 all excl
        '{8'hFF, 1'b0, 2'b01, 3'd0, 8'h01}   // R1 dest ignored
    };
    localparam string TAG [0:11] = '{"R2", "R2", "R2", "R3", "R4", "R4",
                                     "R4", "R5", "R1", "R1", "R1", "R1"};

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Drive a request for one cycle, then sample the registered result.
    task automatic issue(input logic [7:0] d, input logic lg, input logic [1:0] sh,
                         input logic [2:0] snd, input logic low);
        @(negedge clk);
        req_valid = 1'b1; req_dest = d; req_logical = lg;
        req_shorthand = sh; req_sender = snd; req_lowest = low;
        @(negedge clk);
        req_valid = 1'b0;
        total++;
        if (dlv_valid !== 1'b1) begin
            bad++;
            $display("FAIL R9: valid got %b expected 1", dlv_valid);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) tgt_phys_id[i*IDW +: IDW] = 8'h10 + 8'(i);
        tgt_log_id = {8'hFF, 8'h31, 8'h22, 8'h21, 8'h08, 8'h04, 8'h02, 8'h01};
        // formats, target 7 down to 0: none, cluster x3, flat x4
        tgt_fmt = {2'b00, 2'b10, 2'b10, 2'b10, 2'b01, 2'b01, 2'b01, 2'b01};

        do_reset();
        @(negedge clk);
        check("R10 valid", {7'd0, dlv_valid}, 8'h00);
        check("R10 mask", dlv_mask, 8'h00);

        for (int v = 0; v < 12; v++) begin
            issue(VEC[v].dest, VEC[v].lg, VEC[v].sh, VEC[v].snd, 1'b0);
            check({TAG[v], " R6 vector"}, dlv_mask, VEC[v].exp);
        end
        @(negedge clk);
        check("R9 idle valid", {7'd0, dlv_valid}, 8'h00);
        check("R9 idle mask", dlv_mask, 8'h00);

        // Lowest priority, all enabled; first search begins at 0 (R10).
        tgt_enable = 8'hFF;
        issue(8'h00, 1'b0, 2'b10, 3'd0, 1'b1); check("R10 R7 first pick", dlv_mask, 8'h01);
        issue(8'h00, 1'b0, 2'b10, 3'd0, 1'b1); check("R7 rotate", dlv_mask, 8'h02);
        issue(8'h00, 1'b0, 2'b10, 3'd0, 1'b1); check("R7 rotate", dlv_mask, 8'h04);
        issue(8'h16, 1'b0, 2'b00, 3'd0, 1'b1); check("R7 single match", dlv_mask, 8'h40);
        issue(8'h00, 1'b0, 2'b10, 3'd0, 1'b1); check("R8 ptr moved", dlv_mask, 8'h80);
        issue(8'h00, 1'b0, 2'b10, 3'd0, 1'b1); check("R7 wrap", dlv_mask, 8'h01);
        tgt_enable = 8'h08;
        issue(8'h00, 1'b0, 2'b10, 3'd0, 1'b1); check("R7 skip disabled", dlv_mask, 8'h08);
        tgt_enable = 8'h00;
        issue(8'h00, 1'b0, 2'b10, 3'd0, 1'b1); check("R8 none qualifies", dlv_mask, 8'h00);
        tgt_enable = 8'hFF;
        issue(8'h00, 1'b0, 2'b10, 3'd0, 1'b1); check("R8 ptr kept", dlv_mask, 8'h10);
        tgt_enable = 8'hDF;
        issue(8'h15, 1'b0, 2'b00, 3'd0, 1'b1); check("R7 match disabled", dlv_mask, 8'h00);
        tgt_enable = 8'hFF;
        issue(8'h00, 1'b0, 2'b11, 3'd5, 1'b1); check("R1 R7 excl sender", dlv_mask, 8'h40);

        // Reset restores the search start.
        do_reset();
        issue(8'h00, 1'b0, 2'b10, 3'd0, 1'b1); check("R10 ptr reset", dlv_mask, 8'h01);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule